// File: doc/BRIEF.md
# Lockable Trigger Routing Selector

This block routes trigger lines between hardware units. A vector of up to 128 trigger inputs comes in. A set of trigger outputs goes out, and each output follows one input picked by a 7-bit selector held in a memory-mapped register. The outputs feed units such as converter start inputs and timer internal-trigger inputs. A register holds either a single selector or four selectors, one in each byte. Bit 31 of every register is a lock. Once software sets it, that register ignores every later write until a reset.

The register bus is a simple single-cycle 32-bit port:
- A read returns data combinationally while the access is presented.
- A write is taken at the clock edge that ends the access.
- Any access that is not a full, aligned word to an implemented register raises an error flag in the same cycle.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

The register map uses word offsets 0x00 through 0x14:
- Offsets 0x00, 0x04, 0x08 and 0x0C each hold one selector and reset to 0. They drive outputs 0 to 3.
- Offset 0x10 holds one selector and resets to 0x0000_0015, which selects source 21. It drives output 4.
- Offset 0x14 holds four selectors and resets to 0x2727_2727. It drives outputs 5 to 8, with output 5 taken from the lowest byte.

Top module: `trig_route_sel`

## Requirements
- R1: After reset, offsets 0x00 to 0x0C read 0x0000_0000, offset 0x10 reads 0x0000_0015, offset 0x14 reads 0x2727_2727, and no register is locked.
- R2: An error-free word write to an unlocked register updates its selector fields, and a read in the next access returns the written field values.
- R3: Each output equals the input line indexed by its selector. The output follows trigger input changes combinationally and reflects a new selector value from the cycle after the write.
- R4: A selector value at or above the number of implemented inputs (parameter NUM_IN) drives a constant 0 on its output.
- R5: Writing 1 to bit 31 sets the register's lock. Writing 0 to bit 31 has no effect. Only a reset clears the lock.
- R6: While a register is locked, every write to it is discarded, including writes to its selector fields and to bit 31. Other registers remain writable.
- R7: A single write that sets bit 31 and changes the selectors applies both changes.
- R8: Bits that hold neither a selector nor the lock read as 0, and write data in them is discarded. Single-selector registers use bits 6:0. The four-selector register uses bits 6:0, 14:8, 22:16 and 30:24.
- R9: The size code is 2'b10 for a word, 2'b01 for a halfword and 2'b00 for a byte. Any size other than a word raises bus_err in the same cycle, returns read data 0, and leaves every register unchanged.
- R10: An address that is not word aligned, or that lies beyond offset 0x14, raises bus_err and changes no register.
- R11: The four fields of register 0x14 are independent. The field in bits 8f+6:8f drives output 5+f.
- R12: Reads of a locked register return its current field values with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code (2'b10 = word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 on error or no access |
| bus_err | output | 1 | Access rejected |
| trig_in | input | NUM_IN | Trigger source lines |
| trig_out | output | 9 | Routed trigger outputs |

## Verification
The bench sweeps every selector value through a single-selector register and through all four fields of the packed register. It uses a small input count, so that selector values past the last input are reached. A design that indexed past the vector or wrapped the index would show a stray 1 there.

It aims writes at locked registers in several forms: with the lock bit cleared, with reserved bits set, and with new field values. A lock that is not sticky, or that blocks only the fields, would show up on read-back.

Byte, halfword, misaligned and out-of-range accesses are sent with data that would visibly change a register if it leaked through.

A register that sets the lock and changes its fields in one write is checked for both effects. A design that lets the lock gate its own write would drop the field change.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int SEL_W        = 7;
  localparam int FIELD_STRIDE = 8;
  localparam int LOCK_BIT     = 31;
  localparam int NUM_REGS     = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  function automatic int reg_nfield(int idx);
    return (idx == 5) ? 4 : 1;
  endfunction

  function automatic logic [31:0] reg_rst(int idx);
    case (idx)
      4:       return 32'h0000_0015;
      5:       return 32'h2727_2727;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic int out_base(int idx);
    int b;
    b = 0;
    for (int j = 0; j < idx; j++) b += reg_nfield(j);
    return b;
  endfunction

  localparam int NUM_OUT = out_base(NUM_REGS);
endpackage

// File: rtl/trs_rst_sync.sv
module trs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/trs_decode.sv
module trs_decode
  import trs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = NUM_REGS
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output logic [NREG-1:0]   hit,
  output logic              err
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             size_ok;
  logic             align_ok;
  logic             range_ok;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign size_ok  = (bus_size == SZ_WORD);
  assign align_ok = (bus_addr[1:0] == 2'b00);
  assign range_ok = (int'(word_idx) < NREG);
  assign err      = bus_sel & ~(size_ok & align_ok & range_ok);

  always_comb begin
    hit = '0;
    for (int i = 0; i < NREG; i++) begin
      hit[i] = bus_sel & ~err & (word_idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/trs_sel_reg.sv
module trs_sel_reg
  import trs_pkg::*;
#(
  parameter int          NFIELD  = 1,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [31:0]              wdata,
  output logic [NFIELD*SEL_W-1:0]  sel_o,
  output logic                     lock_o,
  output logic [31:0]              rdata_o
);
  function automatic logic [NFIELD*SEL_W-1:0] unpack(logic [31:0] w);
    logic [NFIELD*SEL_W-1:0] r;
    for (int f = 0; f < NFIELD; f++) begin
      r[f*SEL_W +: SEL_W] = w[f*FIELD_STRIDE +: SEL_W];
    end
    return r;
  endfunction

  localparam logic [NFIELD*SEL_W-1:0] SEL_RST = unpack(RST_VAL);

  logic [NFIELD*SEL_W-1:0] sel_q, sel_d;
  logic                    lock_q, lock_d;
  logic                    upd_en;

  // Clock enable: accepted write and register not locked.
  assign upd_en = wr_en & ~lock_q;

  always_comb begin
    sel_d  = unpack(wdata);
    lock_d = lock_q | wdata[LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_RST;
      lock_q <= RST_VAL[LOCK_BIT];
    end else if (upd_en) begin
      sel_q  <= sel_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < NFIELD; f++) begin
      rdata_o[f*FIELD_STRIDE +: SEL_W] = sel_q[f*SEL_W +: SEL_W];
    end
    rdata_o[LOCK_BIT] = lock_q;
  end

  assign sel_o  = sel_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/trs_mux.sv
module trs_mux
  import trs_pkg::*;
#(
  parameter int NUM_IN = 128
) (
  input  logic [NUM_IN-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              trig_out
);
  // Unmatched (out-of-range) selector values fall through to 0.
  always_comb begin
    trig_out = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel == SEL_W'(i)) trig_out = trig_in[i];
    end
  end
endmodule

// File: rtl/trig_route_sel.sv
module trig_route_sel
  import trs_pkg::*;
#(
  parameter int NUM_IN = 128,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  input  logic [NUM_IN-1:0]  trig_in,
  output logic [NUM_OUT-1:0] trig_out
);
  logic                     srst_n;
  logic [NUM_REGS-1:0]      hit;
  logic [NUM_REGS-1:0]      lock_vec;
  logic [NUM_OUT*SEL_W-1:0] sel_flat;
  logic [31:0]              rdata_arr [NUM_REGS];

  trs_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  trs_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_decode (
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .hit      (hit),
    .err      (bus_err)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int NF = reg_nfield(r);
    localparam int OB = out_base(r);
    trs_sel_reg #(.NFIELD(NF), .RST_VAL(reg_rst(r))) u_reg (
      .clk     (clk),
      .rst_n   (srst_n),
      .wr_en   (hit[r] & bus_we),
      .wdata   (bus_wdata),
      .sel_o   (sel_flat[OB*SEL_W +: NF*SEL_W]),
      .lock_o  (lock_vec[r]),
      .rdata_o (rdata_arr[r])
    );
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    trs_mux #(.NUM_IN(NUM_IN)) u_mux (
      .trig_in  (trig_in),
      .sel      (sel_flat[k*SEL_W +: SEL_W]),
      .trig_out (trig_out[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (hit[r]) bus_rdata = bus_rdata | rdata_arr[r];
    end
  end
endmodule

// File: rtl/trig_route_sel_chk.sv
module trig_route_sel_chk
  import trs_pkg::*;
#(
  parameter int NUM_IN = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic [1:0]               bus_size,
  input logic                     bus_err,
  input logic [31:0]              bus_rdata,
  input logic [NUM_OUT*SEL_W-1:0] sel_flat,
  input logic [NUM_REGS-1:0]      lock_vec,
  input logic [NUM_OUT-1:0]       trig_out
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_lock
    localparam int OB = out_base(r);
    localparam int NF = reg_nfield(r);
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[r] |=> lock_vec[r]);
    a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[r] |=> $stable(sel_flat[OB*SEL_W +: NF*SEL_W]));
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_rng
    a_r4_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_flat[k*SEL_W +: SEL_W]) >= NUM_IN) |-> !trig_out[k]);
  end

  a_r9_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SZ_WORD) |-> bus_err);

  a_r9_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(sel_flat) && $stable(lock_vec)));

  a_r9_err_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'h0));
endmodule

bind trig_route_sel trig_route_sel_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_size  (bus_size),
  .bus_err   (bus_err),
  .bus_rdata (bus_rdata),
  .sel_flat  (sel_flat),
  .lock_vec  (lock_vec),
  .trig_out  (trig_out)
);

// File: tb/trig_route_sel_tb.sv
`timescale 1ns/1ps
module trig_route_sel_tb;
  localparam int NIN  = 40;
  localparam int NOUT = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic [NIN-1:0]  trig_in;
  logic [NOUT-1:0] trig_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [6];

  always #4 clk = ~clk;

  trig_route_sel #(.NUM_IN(NIN), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .trig_in(trig_in),
    .trig_out(trig_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fmask(int r);
    return (r == 5) ? 32'h7F7F_7F7F : 32'h0000_007F;
  endfunction

  function automatic logic [NOUT-1:0] exp_out();
    logic [NOUT-1:0] e;
    for (int k = 0; k < NOUT; k++) begin
      int r, f, s;
      r = (k < 5) ? k : 5;
      f = (k < 5) ? 0 : k - 5;
      s = int'((mdl[r] >> (8 * f)) & 32'h7F);
      e[k] = (s < NIN) ? trig_in[s] : 1'b0;
    end
    return e;
  endfunction

  task automatic mdl_reset();
    for (int r = 0; r < 4; r++) mdl[r] = 32'h0;
    mdl[4] = 32'h0000_0015;
    mdl[5] = 32'h2727_2727;
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1;
    rd = bus_rdata; er = bus_err;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  function automatic bit exp_err(input logic [7:0] a, input logic [1:0] sz);
    return (sz != 2'b10) || (a[1:0] != 2'b00) || ((a >> 2) >= 6);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd, input string req);
    logic [31:0] rd; logic er; int r;
    access(1'b1, a, sz, wd, rd, er);
    chk(er == exp_err(a, sz), req, {31'h0, er}, {31'h0, exp_err(a, sz)});
    if (!exp_err(a, sz)) begin
      r = int'(a >> 2);
      if (!mdl[r][31]) mdl[r] = (wd & fmask(r)) | ((mdl[r] | wd) & 32'h8000_0000);
    end
  endtask

  task automatic rd_chk(input int r, input string req);
    logic [31:0] rd; logic er;
    access(1'b0, 8'(r * 4), 2'b10, 32'h0, rd, er);
    chk(!er && rd == mdl[r], req, rd, mdl[r]);
  endtask

  task automatic out_chk(input logic [NIN-1:0] pat, input string req);
    @(negedge clk);
    trig_in = pat;
    #1;
    chk(trig_out == exp_out(), req, 32'(trig_out), 32'(exp_out()));
  endtask

  task automatic all_regs(input string req);
    for (int r = 0; r < 6; r++) rd_chk(r, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mdl_reset();
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_size = 2'b10; bus_wdata = '0; trig_in = '0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values and routing from reset selectors
    all_regs("R1");
    out_chk({NIN{1'b1}}, "R1");
    out_chk(NIN'(1) << 21, "R3");

    // R2 R3 R4 R8: sweep every selector through reg 0, with reserved bits set
    for (int s = 0; s < 128; s++) begin
      wr(8'h00, 2'b10, 32'h7FFF_FF80 | 32'(s), "R8");
      rd_chk(0, "R8");
      out_chk((s < NIN) ? (NIN'(1) << s) : {NIN{1'b1}}, "R4");
      out_chk((s < NIN) ? ~(NIN'(1) << s) : {NIN{1'b1}}, "R3");
    end

    // R11: independent fields of the four-selector register
    for (int v = 0; v < 128; v++) begin
      logic [31:0] w;
      w = {1'b0, 7'((v + 93) % 128), 1'b1, 7'((v + 62) % 128),
           1'b1, 7'((v + 31) % 128), 1'b1, 7'(v)};
      wr(8'h14, 2'b10, w, "R11");
      rd_chk(5, "R11");
      out_chk(NIN'(1) << (v % NIN), "R11");
      out_chk({NIN{1'b1}}, "R11");
    end

    // R9: non-word sizes rejected, nothing changes
    for (int sz = 0; sz < 2; sz++) begin
      access(1'b1, 8'h04, 2'(sz), 32'h8000_0033, rd, er);
      chk(er && rd == 32'h0, "R9", {rd[30:0], er}, 32'h1);
      access(1'b0, 8'h10, 2'(sz), 32'h0, rd, er);
      chk(er && rd == 32'h0, "R9", {rd[30:0], er}, 32'h1);
    end
    all_regs("R9");

    // R10: misaligned and out-of-range addresses
    wr(8'h06, 2'b10, 32'h8000_0044, "R10");
    wr(8'h18, 2'b10, 32'h8000_0044, "R10");
    wr(8'hFC, 2'b10, 32'h8000_0044, "R10");
    access(1'b0, 8'h1C, 2'b10, 32'h0, rd, er);
    chk(er && rd == 32'h0, "R10", {rd[30:0], er}, 32'h1);
    all_regs("R10");

    // R5: writing 0 to bit 31 does not lock
    wr(8'h04, 2'b10, 32'h0000_0005, "R5");
    wr(8'h04, 2'b10, 32'h0000_0006, "R5");
    rd_chk(1, "R5");
    // R7: lock and field change in one write
    wr(8'h04, 2'b10, 32'h8000_0003, "R7");
    rd_chk(1, "R7");
    chk(mdl[1] == 32'h8000_0003, "R7", mdl[1], 32'h8000_0003);
    out_chk(NIN'(1) << 3, "R7");
    // R6 R12: locked register ignores writes and still reads back
    wr(8'h04, 2'b10, 32'h0000_0010, "R6");
    wr(8'h04, 2'b10, 32'h7FFF_FFFF, "R6");
    rd_chk(1, "R12");
    out_chk(NIN'(1) << 3, "R6");
    wr(8'h08, 2'b10, 32'h0000_0009, "R6");
    rd_chk(2, "R6");
    wr(8'h14, 2'b10, 32'h8102_0304, "R7");
    wr(8'h14, 2'b10, 32'h0506_0708, "R6");
    rd_chk(5, "R12");
    out_chk({NIN{1'b1}}, "R6");

    // R5: only reset clears the lock
    do_reset();
    all_regs("R5");
    wr(8'h04, 2'b10, 32'h0000_0011, "R5");
    rd_chk(1, "R5");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule